// File: doc/BRIEF.md
# Prescaled Up/Down Interrupt Timer

This block is the interrupt timer of a cartridge bank controller. A prescaler feeds an 8-bit main counter, and the pair is advanced by one of four single-cycle event strobes: CPU bus cycles, rising edges of the PPU address line A12, PPU reads, or CPU writes. Software sets the counting direction to up, down or stopped. It can also narrow the prescaler to its low three bits. When the main counter wraps while the interrupt is enabled, a level interrupt line is raised.

All control goes through a write-only port with a 3-bit offset. The register at offset 6 holds an XOR mask. Every load of the prescaler or of the main counter stores the written byte XOR that mask. The interrupt line stays high until software acknowledges it.

Top module: `evt_irq_timer`

## Requirements
- R1: After reset the interrupt line is low, the enable is off, the mode selects stopped counting from source 0 with the 8-bit prescaler, and the mask, prescaler and counter are zero.
- R2: A write to offset 0 sets the enable from data bit 0. A write there with bit 0 clear also drops a pending interrupt. A write with bit 0 set leaves it pending.
- R3: A write to offset 2 clears the enable and drops a pending interrupt. A write to offset 3 sets the enable and leaves a pending interrupt as it is. Enabling does not raise a wrap that was missed while disabled.
- R4: Offset 1 is the mode. Bits 7:6 = 01 count up and 10 count down. 00 and 11 stop counting, and the prescaler and counter then keep their values.
- R5: Mode bits 1:0 pick the source: 0 CPU cycle, 1 A12 rise, 2 PPU read, 3 CPU write. Strobes on the other sources are ignored.
- R6: A write to offset 6 stores the mask. A write to offset 4 loads the prescaler with data XOR mask. A write to offset 5 loads the counter with data XOR mask.
- R7: Counting up, each selected event increments the prescaler. When the prescaler bits in use become all zero, the counter increments.
- R8: Counting down, each selected event decrements the prescaler. When the prescaler bits in use become all ones, the counter decrements.
- R9: Mode bit 2 set limits the prescaler test to its low 3 bits, so the counter steps once every 8 events. Clear uses all 8 bits.
- R10: The interrupt rises one cycle after the counter wraps to 0x00 counting up, or to 0xFF counting down. This happens only if the enable was set before that cycle.
- R11: A raised interrupt stays high until acknowledged through offset 0 (bit 0 clear) or offset 2. Counter loads do not clear it. An acknowledge wins over a wrap in the same cycle.
- R12: An event in a cycle that writes offset 4 or 5 is discarded. Prescaler and counter take the loaded values only.
- R13: Writes to offset 7 and mode bit 3 have no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_off_i | input | 3 | Register offset |
| wr_data_i | input | 8 | Write data |
| ev_cpu_cycle_i | input | 1 | CPU bus cycle strobe (source 0) |
| ev_a12_rise_i | input | 1 | PPU A12 rising-edge strobe (source 1) |
| ev_ppu_read_i | input | 1 | PPU read strobe (source 2) |
| ev_cpu_write_i | input | 1 | CPU write strobe (source 3) |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions check the following on every cycle:
- Single prescaler steps in both directions.
- Values held while stopped.
- Loads taking precedence over events.
- The counter value that follows a wrap.
- Interrupt stickiness.
- Acknowledge clearing.
- The rule that the line only rises on an enabled wrap.

The bench scenarios show the end-to-end effects that are visible only at the interrupt pin:
- Source selection.
- The XOR on loads.
- The 8-event period of the narrow prescaler.
- The inertness of offset 7.
- Collisions of writes with events.

A behavioural model compared on every clock covers a long stretch of random traffic.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  typedef enum logic [1:0] {
    DIR_HOLD_A = 2'b00,
    DIR_UP     = 2'b01,
    DIR_DN     = 2'b10,
    DIR_HOLD_B = 2'b11
  } dir_e;

  typedef enum logic [2:0] {
    OFF_ENA  = 3'd0,
    OFF_MODE = 3'd1,
    OFF_DIS  = 3'd2,
    OFF_ARM  = 3'd3,
    OFF_PRE  = 3'd4,
    OFF_CNT  = 3'd5,
    OFF_XOR  = 3'd6,
    OFF_ADJ  = 3'd7
  } off_e;

  // mode byte field positions
  localparam int MODE_DIR_LSB = 6;
  localparam int MODE_NARROW  = 2;
  localparam int MODE_SRC_LSB = 0;
  localparam int SRC_N        = 4;
  localparam int SRC_W        = $clog2(SRC_N);

  typedef struct packed {
    dir_e             dir;
    logic             narrow;
    logic [SRC_W-1:0] src;
  } mode_t;

endpackage

// File: rtl/evt_irq_regs.sv
module evt_irq_regs
  import evt_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_off_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output mode_t             mode_o,
  output logic              en_o,
  output logic              ack_o,
  output logic              ld_pre_o,
  output logic              ld_cnt_o,
  output logic [DATA_W-1:0] ld_val_o
);

  mode_t             mode_q;
  logic              en_q;
  logic [DATA_W-1:0] xor_q;
  off_e              off;

  assign off = off_e'(wr_off_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      en_q   <= 1'b0;
      xor_q  <= '0;
    end else if (wr_en_i) begin
      case (off)
        OFF_ENA:  en_q <= wr_data_i[0];
        OFF_MODE: begin
          mode_q.dir    <= dir_e'(wr_data_i[MODE_DIR_LSB+:2]);
          mode_q.narrow <= wr_data_i[MODE_NARROW];
          mode_q.src    <= wr_data_i[MODE_SRC_LSB+:SRC_W];
        end
        OFF_DIS:  en_q  <= 1'b0;
        OFF_ARM:  en_q  <= 1'b1;
        OFF_XOR:  xor_q <= wr_data_i;
        default:  ;  // OFF_PRE/OFF_CNT handled by core, OFF_ADJ inert
      endcase
    end
  end

  assign mode_o   = mode_q;
  assign en_o     = en_q;
  assign ack_o    = wr_en_i && ((off == OFF_ENA && !wr_data_i[0]) || off == OFF_DIS);
  assign ld_pre_o = wr_en_i && off == OFF_PRE;
  assign ld_cnt_o = wr_en_i && off == OFF_CNT;
  assign ld_val_o = wr_data_i ^ xor_q;

  p_arm_sets_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_off_i == OFF_ARM) |=> en_q);
  p_dis_clears_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_off_i == OFF_DIS) |=> !en_q);
  p_adj_inert_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_off_i == OFF_ADJ) |=> ($stable(mode_q) && $stable(en_q) && $stable(xor_q)));

endmodule

// File: rtl/evt_irq_src_sel.sv
module evt_irq_src_sel #(
  parameter int SRC_N = 4,
  localparam int SEL_W = $clog2(SRC_N)
) (
  input  logic [SRC_N-1:0] ev_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             ev_o
);

  logic [SRC_N-1:0] hit;

  for (genvar g = 0; g < SRC_N; g++) begin : g_src
    assign hit[g] = ev_i[g] && (sel_i == SEL_W'(g));
  end

  assign ev_o = |hit;

endmodule

// File: rtl/evt_irq_core.sv
module evt_irq_core
  import evt_irq_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NARROW_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  dir_e              dir_i,
  input  logic              narrow_i,
  input  logic              ld_pre_i,
  input  logic              ld_cnt_i,
  input  logic [DATA_W-1:0] ld_val_i,
  output logic              wrap_o
);

  localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] ONE      = DATA_W'(1);

  logic [DATA_W-1:0] pre_q, cnt_q, pre_nxt, cnt_nxt, pmask, narrow_mask;
  logic              up, run, step_en, pre_tc;

  if (NARROW_W >= DATA_W) begin : g_full_narrow
    assign narrow_mask = ALL_ONES;
  end else begin : g_part_narrow
    assign narrow_mask = ALL_ONES >> (DATA_W - NARROW_W);
  end

  assign pmask   = narrow_i ? narrow_mask : ALL_ONES;
  assign up      = (dir_i == DIR_UP);
  assign run     = (dir_i == DIR_UP) || (dir_i == DIR_DN);
  assign step_en = step_i && run && !ld_pre_i && !ld_cnt_i;
  assign pre_nxt = up ? pre_q + ONE : pre_q - ONE;
  assign pre_tc  = up ? ((pre_nxt & pmask) == '0) : ((pre_nxt & pmask) == pmask);
  assign cnt_nxt = up ? cnt_q + ONE : cnt_q - ONE;
  assign wrap_o  = step_en && pre_tc && (up ? (cnt_nxt == '0) : (cnt_nxt == ALL_ONES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      if (ld_pre_i)     pre_q <= ld_val_i;
      else if (step_en) pre_q <= pre_nxt;
      if (ld_cnt_i)               cnt_q <= ld_val_i;
      else if (step_en && pre_tc) cnt_q <= cnt_nxt;
    end
  end

  p_stop_holds_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(dir_i == DIR_UP || dir_i == DIR_DN) && !ld_pre_i && !ld_cnt_i)
      |=> ($stable(pre_q) && $stable(cnt_q)));
  p_up_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && dir_i == DIR_UP && !ld_pre_i && !ld_cnt_i)
      |=> pre_q == $past(pre_q) + ONE);
  p_dn_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && dir_i == DIR_DN && !ld_pre_i && !ld_cnt_i)
      |=> pre_q == $past(pre_q) - ONE);
  p_load_wins_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_cnt_i |=> cnt_q == $past(ld_val_i));
  p_load_pre_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_pre_i |=> pre_q == $past(ld_val_i));
  p_wrap_value_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> ($past(dir_i) == DIR_UP ? cnt_q == '0 : cnt_q == ALL_ONES));

endmodule

// File: rtl/evt_irq_flag.sv
module evt_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wrap_i,
  input  logic en_i,
  input  logic ack_i,
  output logic irq_o
);

  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_q <= 1'b0;
    else if (ack_i) irq_q <= 1'b0;
    else if (wrap_i && en_i) irq_q <= 1'b1;
  end

  assign irq_o = irq_q;

  p_rise_needs_en_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_q && !(wrap_i && en_i)) |=> !irq_q);
  p_ack_clears_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !irq_q);
  p_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !ack_i) |=> irq_q);

endmodule

// File: rtl/evt_irq_timer.sv
module evt_irq_timer
  import evt_irq_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NARROW_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_off_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ev_cpu_cycle_i,
  input  logic              ev_a12_rise_i,
  input  logic              ev_ppu_read_i,
  input  logic              ev_cpu_write_i,
  output logic              irq_o
);

  mode_t             mode;
  logic              en, ack, ld_pre, ld_cnt, step, wrap;
  logic [DATA_W-1:0] ld_val;
  logic [SRC_N-1:0]  ev_vec;

  assign ev_vec = {ev_cpu_write_i, ev_ppu_read_i, ev_a12_rise_i, ev_cpu_cycle_i};

  evt_irq_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_off_i (wr_off_i),
    .wr_data_i(wr_data_i),
    .mode_o   (mode),
    .en_o     (en),
    .ack_o    (ack),
    .ld_pre_o (ld_pre),
    .ld_cnt_o (ld_cnt),
    .ld_val_o (ld_val)
  );

  evt_irq_src_sel #(.SRC_N(SRC_N)) u_src (
    .ev_i (ev_vec),
    .sel_i(mode.src),
    .ev_o (step)
  );

  evt_irq_core #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .dir_i   (mode.dir),
    .narrow_i(mode.narrow),
    .ld_pre_i(ld_pre),
    .ld_cnt_i(ld_cnt),
    .ld_val_i(ld_val),
    .wrap_o  (wrap)
  );

  evt_irq_flag u_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wrap_i(wrap),
    .en_i  (en),
    .ack_i (ack),
    .irq_o (irq_o)
  );

endmodule

// File: tb/evt_irq_timer_test.sv
module evt_irq_timer_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_off = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] ev = '0;
  logic       irq;

  int    checks = 0;
  int    errors = 0;
  bit    running = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_en, m_irq, m_mode, m_mask, m_pre, m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_irq_timer uut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .wr_en_i       (wr_en),
    .wr_off_i      (wr_off),
    .wr_data_i     (wr_data),
    .ev_cpu_cycle_i(ev[0]),
    .ev_a12_rise_i (ev[1]),
    .ev_ppu_read_i (ev[2]),
    .ev_cpu_write_i(ev[3]),
    .irq_o         (irq)
  );

  always @(posedge clk or negedge rst_n) begin
    int dir, pm, fire, d, off, hit, ack, ld;
    if (!rst_n) begin
      m_en = 0; m_irq = 0; m_mode = 0; m_mask = 0; m_pre = 0; m_cnt = 0;
    end else begin
      dir  = (m_mode >> 6) & 3;
      pm   = ((m_mode >> 2) & 1) ? 7 : 255;
      d    = int'(wr_data);
      off  = int'(wr_off);
      hit  = int'(ev[m_mode & 3]);
      ld   = (wr_en && (off == 4 || off == 5)) ? 1 : 0;
      ack  = (wr_en && ((off == 0 && (d & 1) == 0) || off == 2)) ? 1 : 0;
      fire = 0;
      if (hit == 1 && ld == 0 && dir == 1) begin
        m_pre = (m_pre + 1) % 256;
        if ((m_pre & pm) == 0) begin
          m_cnt = (m_cnt + 1) % 256;
          if (m_cnt == 0 && m_en == 1) fire = 1;
        end
      end else if (hit == 1 && ld == 0 && dir == 2) begin
        m_pre = (m_pre + 255) % 256;
        if ((m_pre & pm) == pm) begin
          m_cnt = (m_cnt + 255) % 256;
          if (m_cnt == 255 && m_en == 1) fire = 1;
        end
      end
      if (ack == 1) m_irq = 0;
      else if (fire == 1) m_irq = 1;
      if (wr_en) begin
        case (off)
          0: m_en = d & 1;
          1: m_mode = d;
          2: m_en = 0;
          3: m_en = 1;
          4: m_pre = d ^ m_mask;
          5: m_cnt = d ^ m_mask;
          6: m_mask = d;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (running && rst_n) begin
      checks++;
      if (int'(irq) != m_irq) begin
        errors++;
        $display("FAIL %s model compare: irq_o=%0d expected %0d at %0t", cur_req, irq, m_irq, $time);
      end
    end
  end

  task automatic chk(input logic exp, input string req);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s: irq_o=%0b expected %0b at %0t", req, irq, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] off, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_off = off; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input int src);
    @(negedge clk);
    ev[src] = 1'b1;
    @(negedge clk);
    ev = '0;
  endtask

  task automatic finish_run();
    running = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    running = 1;
    @(negedge clk);
    cur_req = "R1";
    chk(1'b0, "R1");
    // stopped after reset: events and enable raise nothing
    wr(3'd3, 8'h00);
    for (int i = 0; i < 300; i++) pulse(0);
    chk(1'b0, "R1");

    cur_req = "R7";
    wr(3'd1, 8'h40); wr(3'd4, 8'hFE); wr(3'd5, 8'hFF);
    pulse(0); chk(1'b0, "R7");
    pulse(0); chk(1'b1, "R10");

    cur_req = "R11";
    wr(3'd5, 8'h10); chk(1'b1, "R11");
    wr(3'd0, 8'h01); chk(1'b1, "R2");
    wr(3'd0, 8'h00); chk(1'b0, "R2");

    cur_req = "R3";
    wr(3'd3, 8'h00); wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
    pulse(0); chk(1'b1, "R10");
    wr(3'd3, 8'h00); chk(1'b1, "R3");
    wr(3'd2, 8'h00); chk(1'b0, "R3");
    wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
    pulse(0); chk(1'b0, "R10");
    wr(3'd3, 8'h00); chk(1'b0, "R3");

    cur_req = "R8";
    wr(3'd1, 8'h82); wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    pulse(2); chk(1'b1, "R8");
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd4, 8'h00); wr(3'd5, 8'h01);
    pulse(2); chk(1'b0, "R8");
    pulse(2); chk(1'b0, "R9");

    cur_req = "R9";
    wr(3'd6, 8'h0F); wr(3'd1, 8'h45);
    wr(3'd4, 8'h0F); wr(3'd5, 8'hF0);
    for (int i = 0; i < 7; i++) pulse(1);
    chk(1'b0, "R9");
    pulse(1); chk(1'b1, "R9");
    chk(1'b1, "R6");
    wr(3'd2, 8'h00); wr(3'd6, 8'h00);

    cur_req = "R5";
    wr(3'd3, 8'h00); wr(3'd1, 8'h43); wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
    pulse(0); pulse(1); pulse(2); chk(1'b0, "R5");
    pulse(3); chk(1'b1, "R5");
    wr(3'd2, 8'h00);

    cur_req = "R12";
    wr(3'd3, 8'h00); wr(3'd1, 8'h40); wr(3'd4, 8'hFF);
    @(negedge clk);
    wr_en = 1'b1; wr_off = 3'd5; wr_data = 8'hFF; ev[0] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; ev = '0;
    chk(1'b0, "R12");
    pulse(0); chk(1'b1, "R12");
    wr(3'd2, 8'h00);

    cur_req = "R13";
    wr(3'd3, 8'h00); wr(3'd1, 8'h48); wr(3'd7, 8'hFF);
    wr(3'd4, 8'hFE); wr(3'd5, 8'hFF);
    pulse(0); chk(1'b0, "R13");
    pulse(0); chk(1'b1, "R13");
    wr(3'd2, 8'h00);

    cur_req = "R4";
    wr(3'd3, 8'h00); wr(3'd1, 8'hC0); wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
    for (int i = 0; i < 20; i++) pulse(0);
    chk(1'b0, "R4");
    wr(3'd1, 8'h00); pulse(0); chk(1'b0, "R4");
    wr(3'd1, 8'h40); pulse(0); chk(1'b1, "R4");

    cur_req = "R11";
    wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
    @(negedge clk);
    wr_en = 1'b1; wr_off = 3'd0; wr_data = 8'h00; ev[0] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; ev = '0;
    chk(1'b0, "R11");
    wr(3'd0, 8'h01); wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
    pulse(0); chk(1'b1, "R2");

    cur_req = "R7 random";
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      wr_en   = ($urandom_range(0, 5) == 0);
      wr_off  = 3'($urandom_range(0, 7));
      wr_data = 8'($urandom);
      if (wr_off == 3'd1) wr_data[7:6] = ($urandom_range(0, 3) == 0) ? 2'b11 : 2'($urandom_range(1, 2));
      ev      = 4'($urandom);
    end
    @(negedge clk);
    wr_en = 1'b0; ev = '0;
    @(negedge clk);
    finish_run();
  end

endmodule